// File: doc/BRIEF.md
# Alert and Status Register Bank

This block is a byte-addressed register bank for a USB Type-C power provider. It sits behind a simple parallel read/write bus that an I2C target engine drives. It shows three live status words to the bus: CC connection, VBUS monitoring and hardware faults. Each word has a companion transition register. The transition register records every bit that changed and is cleared by reading it. A sticky summary register gathers the three transition registers into one alert line, and a mask register gates that line. The alert line is active low.

The bank also holds three read/write control bytes: discharge timing, discharge control and monitoring shift. It passes the power-path enable status through as a read-only byte. It also forms the 7-bit bus address from a fixed `0101` prefix and three strap pins. The strap pins are captured once, on the first clock after reset.

Top module: `alert_reg_bank`

## Requirements
- R1: While reset is asserted and right after it is released, the bank is in its reset state. The mask reads 0x00 and the discharge time reads 0x95. Discharge control reads 0x01 and monitoring control reads 0x00. Every transition register and the summary read 0, and `alertN` is 1.
- R2: Reads of the live status bytes return the inputs in the same cycle. Address 0x0E returns `ccStatus`, 0x10 returns `monStatus`, 0x13 returns `faultStatus` and 0x27 returns `pathEnStatus`.
- R3: On each clock, a transition bit sets when its status bit differs from the value sampled on the previous clock. The sampled copy starts at zero after reset. The transition registers are at 0x0D (CC), 0x0F (monitoring) and 0x12 (faults).
- R4: A read pulse at a read-clear address returns the current value during that cycle. The register is zero after the clock edge that ends the pulse. The read-clear addresses are 0x0B, 0x0D, 0x0F and 0x12.
- R5: If a transition bit sets on the same edge as a read-clear, the new bit is kept.
- R6: Summary register 0x0B uses bits 2:0. Bit 0 stands for CC, bit 1 for monitoring and bit 2 for faults. A summary bit sets on the edge after its transition register is nonzero, and it stays set until 0x0B is read. On that edge a set wins over the clear. Bits 7:3 read 0.
- R7: `alertN` is 0 exactly when some summary bit n is 1 and mask bit n at 0x0C is 0.
- R8: A write pulse updates the addressed register on the next edge. The writable addresses are mask 0x0C, `dischTime` 0x25, `dischCtrl` 0x26 and `monCtrl` 0x2E. A write to any other address changes nothing.
- R9: Every address outside the mapped set reads 0x00.
- R10: `devAddr` equals `0101` followed by the strap value sampled on the first clock after reset. Later changes to the strap pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapPins | input | 3 | Address strap pins, captured once after reset |
| busAddr | input | 8 | Register address |
| busWdata | input | 8 | Write data |
| busRd | input | 1 | Read pulse; clears read-clear registers on its edge |
| busWr | input | 1 | Write pulse |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| ccStatus | input | 8 | Live CC connection status |
| monStatus | input | 8 | Live VBUS monitoring status |
| faultStatus | input | 8 | Live hardware fault status |
| pathEnStatus | input | 8 | Live power-path enable status |
| alertN | output | 1 | Active-low alert |
| dischTime | output | 8 | Discharge time control byte |
| dischCtrl | output | 8 | Discharge control byte |
| monCtrl | output | 8 | Monitoring shift control byte |
| devAddr | output | 7 | Bus device address |

## Verification
The bench builds the bank with its default parameters: 8-bit registers, three strap bits and an all-enabled mask at reset. Because the mask starts enabled, the very first status change reaches `alertN` with no setup writes. This makes the two-edge path from a status change to the alert visible from the first stimulus.

The 3-bit strap width lets one value be driven at reset and a different value afterwards, which exposes any late resampling. A behavioural model checks every read address, the alert and all control outputs on every clock. Directed sequences place a status change on the same edge as a read-clear, and random traffic mixes writes to read-only addresses with overlapping reads.

// File: rtl/alert_reg_pkg.sv
package alert_reg_pkg;
  localparam int NUM_SRC = 3;
  localparam int IDX_W   = $clog2(NUM_SRC);

  localparam logic [7:0] ADDR_SUMMARY = 8'h0B;
  localparam logic [7:0] ADDR_MASK    = 8'h0C;
  localparam logic [7:0] ADDR_DTIME   = 8'h25;
  localparam logic [7:0] ADDR_DCTRL   = 8'h26;
  localparam logic [7:0] ADDR_PATH    = 8'h27;
  localparam logic [7:0] ADDR_MCTRL   = 8'h2E;

  // source order: CC connection, VBUS monitoring, hardware faults
  localparam logic [7:0] TRANS_ADDR  [NUM_SRC] = '{8'h0D, 8'h0F, 8'h12};
  localparam logic [7:0] STATUS_ADDR [NUM_SRC] = '{8'h0E, 8'h10, 8'h13};

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SUMMARY, SEL_MASK, SEL_TRANS, SEL_STATUS,
    SEL_DTIME, SEL_DCTRL, SEL_PATH, SEL_MCTRL
  } rdSel_e;

  typedef struct packed {
    logic               wrMask;
    logic               wrDtime;
    logic               wrDctrl;
    logic               wrMctrl;
    logic               clrSummary;
    logic [NUM_SRC-1:0] clrTrans;
    rdSel_e             rdSel;
    logic [IDX_W-1:0]   srcIdx;
  } strobe_t;
endpackage

// File: rtl/alert_reg_ctrl.sv
module alert_reg_ctrl
  import alert_reg_pkg::*;
(
  input  logic [7:0] busAddr,
  input  logic       busRd,
  input  logic       busWr,
  output strobe_t    stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (busAddr == TRANS_ADDR[i]) begin
        stb.rdSel       = SEL_TRANS;
        stb.srcIdx      = IDX_W'(i);
        stb.clrTrans[i] = busRd;
      end
      if (busAddr == STATUS_ADDR[i]) begin
        stb.rdSel  = SEL_STATUS;
        stb.srcIdx = IDX_W'(i);
      end
    end
    case (busAddr)
      ADDR_SUMMARY: begin
        stb.rdSel      = SEL_SUMMARY;
        stb.clrSummary = busRd;
      end
      ADDR_MASK: begin
        stb.rdSel  = SEL_MASK;
        stb.wrMask = busWr;
      end
      ADDR_DTIME: begin
        stb.rdSel   = SEL_DTIME;
        stb.wrDtime = busWr;
      end
      ADDR_DCTRL: begin
        stb.rdSel   = SEL_DCTRL;
        stb.wrDctrl = busWr;
      end
      ADDR_MCTRL: begin
        stb.rdSel   = SEL_MCTRL;
        stb.wrMctrl = busWr;
      end
      ADDR_PATH: stb.rdSel = SEL_PATH;
      default: ;
    endcase
  end
endmodule

// File: rtl/alert_reg_dp.sv
module alert_reg_dp
  import alert_reg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] DEV_PREFIX = 4'b0101,
  parameter logic [DATA_W-1:0] MASK_RST  = '0,
  parameter logic [DATA_W-1:0] DTIME_RST = 8'h95,
  parameter logic [DATA_W-1:0] DCTRL_RST = 8'h01,
  parameter logic [DATA_W-1:0] MCTRL_RST = 8'h00
)(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0]              pathEn,
  input  logic [STRAP_W-1:0]             strap,
  output logic [DATA_W-1:0]              rdata,
  output logic                           alertN,
  output logic [DATA_W-1:0]              dischTime,
  output logic [DATA_W-1:0]              dischCtrl,
  output logic [DATA_W-1:0]              monCtrl,
  output logic [6:0]                     devAddr
);
  logic [DATA_W-1:0]  transQ [NUM_SRC];
  logic [NUM_SRC-1:0] transAny;
  logic [NUM_SRC-1:0] sumQ;
  logic [DATA_W-1:0]  maskQ;
  logic [STRAP_W-1:0] strapQ;
  logic               strapDone;

  // per-source edge capture: set beats clear so no change is lost
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [DATA_W-1:0] prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevQ     <= '0;
        transQ[g] <= '0;
      end else begin
        prevQ     <= statusIn[g];
        transQ[g] <= (stb.clrTrans[g] ? '0 : transQ[g]) | (statusIn[g] ^ prevQ);
      end
    end
    assign transAny[g] = |transQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ      <= '0;
      maskQ     <= MASK_RST;
      dischTime <= DTIME_RST;
      dischCtrl <= DCTRL_RST;
      monCtrl   <= MCTRL_RST;
      strapQ    <= '0;
      strapDone <= 1'b0;
    end else begin
      sumQ <= (stb.clrSummary ? '0 : sumQ) | transAny;
      if (stb.wrMask)  maskQ     <= wdata;
      if (stb.wrDtime) dischTime <= wdata;
      if (stb.wrDctrl) dischCtrl <= wdata;
      if (stb.wrMctrl) monCtrl   <= wdata;
      if (!strapDone) begin
        strapQ    <= strap;
        strapDone <= 1'b1;
      end
    end
  end

  assign alertN  = ~|(sumQ & ~maskQ[NUM_SRC-1:0]);
  assign devAddr = {DEV_PREFIX, strapQ};

  always_comb begin
    case (stb.rdSel)
      SEL_SUMMARY: rdata = {{(DATA_W-NUM_SRC){1'b0}}, sumQ};
      SEL_MASK:    rdata = maskQ;
      SEL_TRANS:   rdata = transQ[stb.srcIdx];
      SEL_STATUS:  rdata = statusIn[stb.srcIdx];
      SEL_DTIME:   rdata = dischTime;
      SEL_DCTRL:   rdata = dischCtrl;
      SEL_PATH:    rdata = pathEn;
      SEL_MCTRL:   rdata = monCtrl;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/alert_reg_bank.sv
module alert_reg_bank
  import alert_reg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] DEV_PREFIX = 4'b0101,
  parameter logic [DATA_W-1:0] MASK_RST  = '0,
  parameter logic [DATA_W-1:0] DTIME_RST = 8'h95,
  parameter logic [DATA_W-1:0] DCTRL_RST = 8'h01,
  parameter logic [DATA_W-1:0] MCTRL_RST = 8'h00
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic [7:0]         busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busRd,
  input  logic               busWr,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [DATA_W-1:0]  ccStatus,
  input  logic [DATA_W-1:0]  monStatus,
  input  logic [DATA_W-1:0]  faultStatus,
  input  logic [DATA_W-1:0]  pathEnStatus,
  output logic               alertN,
  output logic [DATA_W-1:0]  dischTime,
  output logic [DATA_W-1:0]  dischCtrl,
  output logic [DATA_W-1:0]  monCtrl,
  output logic [6:0]         devAddr
);
  strobe_t stb;
  logic [NUM_SRC-1:0][DATA_W-1:0] statusVec;

  assign statusVec = {faultStatus, monStatus, ccStatus};

  alert_reg_ctrl u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .stb     (stb)
  );

  alert_reg_dp #(
    .DATA_W(DATA_W), .STRAP_W(STRAP_W), .DEV_PREFIX(DEV_PREFIX),
    .MASK_RST(MASK_RST), .DTIME_RST(DTIME_RST),
    .DCTRL_RST(DCTRL_RST), .MCTRL_RST(MCTRL_RST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (busWdata),
    .statusIn  (statusVec),
    .pathEn    (pathEnStatus),
    .strap     (strapPins),
    .rdata     (busRdata),
    .alertN    (alertN),
    .dischTime (dischTime),
    .dischCtrl (dischCtrl),
    .monCtrl   (monCtrl),
    .devAddr   (devAddr)
  );
endmodule

// File: rtl/alert_reg_chk.sv
module alert_reg_chk
  import alert_reg_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] ccStatus,
  input logic [DATA_W-1:0] dischTime,
  input logic [DATA_W-1:0] dischCtrl,
  input logic [DATA_W-1:0] monCtrl,
  input logic [6:0]        devAddr
);
  logic [1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  function automatic logic isMapped(input logic [7:0] a);
    logic hit;
    hit = (a == ADDR_SUMMARY) || (a == ADDR_MASK) || (a == ADDR_DTIME) ||
          (a == ADDR_DCTRL) || (a == ADDR_PATH) || (a == ADDR_MCTRL);
    for (int i = 0; i < NUM_SRC; i++)
      hit = hit || (a == TRANS_ADDR[i]) || (a == STATUS_ADDR[i]);
    return hit;
  endfunction

  assert_live_cc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == STATUS_ADDR[0]) |-> (busRdata == ccStatus));

  assert_write_dtime_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_DTIME) |=> (dischTime == $past(busWdata)));

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> ($stable(dischTime) && $stable(dischCtrl) && $stable(monCtrl)));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped(busAddr) |-> (busRdata == '0));

  assert_devaddr_fixed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2) |-> $stable(devAddr));
endmodule

bind alert_reg_bank alert_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
  .busWr(busWr), .busRdata(busRdata), .ccStatus(ccStatus),
  .dischTime(dischTime), .dischCtrl(dischCtrl), .monCtrl(monCtrl),
  .devAddr(devAddr)
);

// File: tb/sim_alert_reg_bank.sv
`timescale 1ns/1ps
module sim_alert_reg_bank;
  logic       clk = 0;
  logic       rstN = 0;
  logic [2:0] strapPins = 3'b101;
  logic [7:0] busAddr = 8'h00, busWdata = 8'h00;
  logic       busRd = 0, busWr = 0;
  logic [7:0] busRdata;
  logic [7:0] ccStatus = 0, monStatus = 0, faultStatus = 0, pathEnStatus = 0;
  logic       alertN;
  logic [7:0] dischTime, dischCtrl, monCtrl;
  logic [6:0] devAddr;

  int compared = 0, mismatched = 0, cycles = 0;
  bit started = 0, resetPhase = 0;

  always #10 clk = ~clk;

  alert_reg_bank u0 (
    .clk(clk), .rstN(rstN), .strapPins(strapPins), .busAddr(busAddr),
    .busWdata(busWdata), .busRd(busRd), .busWr(busWr), .busRdata(busRdata),
    .ccStatus(ccStatus), .monStatus(monStatus), .faultStatus(faultStatus),
    .pathEnStatus(pathEnStatus), .alertN(alertN), .dischTime(dischTime),
    .dischCtrl(dischCtrl), .monCtrl(monCtrl), .devAddr(devAddr)
  );

  // behavioural reference model
  int mPrev[3] = '{0, 0, 0};
  int mTrans[3] = '{0, 0, 0};
  int mSum = 0, mMask = 0, mDt = 'h95, mDc = 'h01, mMc = 0, mStrap = 0;
  bit mSampled = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPrev = '{0, 0, 0}; mTrans = '{0, 0, 0};
      mSum = 0; mMask = 0; mDt = 'h95; mDc = 'h01; mMc = 0;
      mStrap = 0; mSampled = 0;
    end else begin
      int st[3];
      int a;
      st[0] = ccStatus; st[1] = monStatus; st[2] = faultStatus;
      a = busAddr;
      // summary sees the transition values from before this edge
      if (busRd && a == 'h0B) mSum = 0;
      for (int i = 0; i < 3; i++) if (mTrans[i] != 0) mSum = mSum | (1 << i);
      for (int i = 0; i < 3; i++) begin
        int ta;
        ta = (i == 0) ? 'h0D : (i == 1) ? 'h0F : 'h12;
        if (busRd && a == ta) mTrans[i] = 0;
        mTrans[i] = mTrans[i] | (st[i] ^ mPrev[i]);
        mPrev[i] = st[i];
      end
      if (busWr) begin
        if (a == 'h0C) mMask = busWdata;
        if (a == 'h25) mDt = busWdata;
        if (a == 'h26) mDc = busWdata;
        if (a == 'h2E) mMc = busWdata;
      end
      if (!mSampled) begin mStrap = strapPins; mSampled = 1; end
    end
  end

  function automatic int expRd(input int a);
    case (a)
      'h0B: return mSum;
      'h0C: return mMask;
      'h0D: return mTrans[0];
      'h0F: return mTrans[1];
      'h12: return mTrans[2];
      'h0E: return ccStatus;
      'h10: return monStatus;
      'h13: return faultStatus;
      'h25: return mDt;
      'h26: return mDc;
      'h27: return pathEnStatus;
      'h2E: return mMc;
      default: return 0;
    endcase
  endfunction

  function automatic string tagRd(input int a);
    if (resetPhase) return "R1";
    case (a)
      'h0B: return "R6";
      'h0D, 'h0F, 'h12: return "R3/R4/R5 transition";
      'h0E, 'h10, 'h13, 'h27: return "R2";
      'h0C, 'h25, 'h26, 'h2E: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rstN && started) begin
      int expAlert;
      expAlert = ((mSum & ~mMask & 7) != 0) ? 0 : 1;
      check(busRdata, expRd(busAddr), tagRd(busAddr));
      check(alertN, expAlert, resetPhase ? "R1" : "R7");
      check(dischTime, mDt, resetPhase ? "R1" : "R8");
      check(dischCtrl, mDc, resetPhase ? "R1" : "R8");
      check(monCtrl, mMc, resetPhase ? "R1" : "R8");
      if (mSampled) check(devAddr, {4'b0101, mStrap[2:0]}, "R10");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); #2; endtask
  task automatic idle(input int n);
    busRd = 0; busWr = 0;
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic rdPulse(input int a);
    busAddr = 8'(a); busRd = 1; busWr = 0; step(); busRd = 0;
  endtask
  task automatic wrPulse(input int a, input int d);
    busAddr = 8'(a); busWdata = 8'(d); busWr = 1; busRd = 0; step(); busWr = 0;
  endtask

  int addrList[18] = '{'h0B, 'h0C, 'h0D, 'h0E, 'h0F, 'h10, 'h12, 'h13, 'h25,
                       'h26, 'h27, 'h2E, 'h00, 'h11, 'h24, 'h30, 'h91, 'hFF};

  initial begin
    repeat (3) @(posedge clk);
    step();
    rstN = 1; started = 1; resetPhase = 1;
    // R1 reset state observed over several addresses
    busAddr = 8'h0C; step();
    busAddr = 8'h0D; step();
    busAddr = 8'h0B; step();
    resetPhase = 0;
    strapPins = 3'b010;   // R10: change after the capture must be ignored
    idle(2);
    check(devAddr, 7'b0101101, "R10 strap captured once");

    // R9 reserved reads
    busAddr = 8'h11; #1 check(busRdata, 0, "R9 reserved 0x11"); step();

    // R8 writes, and writes to non-writable addresses
    wrPulse('h25, 'h3C); wrPulse('h26, 'h00); wrPulse('h2E, 'h5A);
    wrPulse('h0E, 'hFF); wrPulse('h27, 'hFF); wrPulse('h0D, 'hFF); wrPulse('h40, 'hFF);
    idle(1);
    check(dischTime, 'h3C, "R8 dischTime write");
    check(monCtrl, 'h5A, "R8 monCtrl write");

    // R3 / R4 on the CC transition register
    ccStatus = 8'h05; idle(2);
    busAddr = 8'h0D; busRd = 1; #1 check(busRdata, 'h05, "R3 transition captured");
    step(); busRd = 0; #1 check(busRdata, 0, "R4 cleared after read");
    step();
    // R5: status change on the same edge as the clear
    busAddr = 8'h0D; busRd = 1; ccStatus = 8'h04; step(); busRd = 0;
    #1 check(busRdata, 'h01, "R5 set wins over clear");
    step();
    // R2 live reads
    pathEnStatus = 8'h81; busAddr = 8'h27; #1 check(busRdata, 'h81, "R2 path status"); step();

    // R6 / R7: summary and mask
    monStatus = 8'h10; idle(3);
    busAddr = 8'h0B; #1 check(busRdata, 'h03, "R6 summary bits"); step();
    check(alertN, 0, "R7 unmasked alert");
    wrPulse('h0C, 'h07); idle(1);
    check(alertN, 1, "R7 masked alert");
    wrPulse('h0C, 'h00);
    rdPulse('h0D); rdPulse('h0F); rdPulse('h0B); idle(1);
    check(alertN, 1, "R6 summary cleared");

    // random traffic, compared every cycle by the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) ccStatus ^= 8'(1 << $urandom_range(0, 7));
      if ($urandom_range(0, 5) == 0) monStatus ^= 8'(1 << $urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) faultStatus ^= 8'(1 << $urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) pathEnStatus = 8'($urandom);
      busAddr = 8'(addrList[$urandom_range(0, 17)]);
      busWdata = 8'($urandom);
      busRd = (op < 4);
      busWr = (op >= 4 && op < 6);
      step();
    end
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule